// File: doc/BRIEF.md
# Branch Trace Ring Buffer

This block keeps a short history of taken control-flow transfers. Each cycle a branch interface may present one transfer: source address, target address, a class code, the privilege of the target, and three flags (mispredicted, inside a transaction, aborted transaction). Transfers that pass the select filter are written into a circular store of depth `DEPTH`. A top-of-stack pointer marks the newest slot. The flags travel in the upper bits of the stored source word.

A control register holds three things: an enable bit, a freeze-on-interrupt bit and a ten-bit select word. The low nine select bits work in suppress mode. A set bit stops one class or privilege from being captured, so software programs the register with a wanted-class mask XORed with 0x1FF. Select bit 9 selects call-stack mode. In that mode the freeze on interrupt is not applied.

A readout walk returns the records newest first, one per cycle. It strips the flags, sign-extends the source address and reports a predicted flag. It folds a duplicated abort record into the record emitted before it. The walk ends with a count strobe. A clear input zeroes every stored address pair.

Top module: `lbr_ring`

## Requirements
- R1: After reset, every slot holds zero addresses and zero flags, so a readout returns `DEPTH` all-zero records and a count of `DEPTH`.
- R2: Readout record i (i = 0 is the first emitted) comes from slot (tos − i) mod `DEPTH`. Each accepted branch advances tos by one, and a branch older than `DEPTH` captures is overwritten.
- R3: Select bit 0 suppresses branches whose target is at the most privileged level (`br_tgt_ring0`=1). Select bit 1 suppresses branches whose target is at any other level.
- R4: The class code c on `br_class` (0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump, 6 far) is suppressed by select bit 2+c. Code 7 is never recorded.
- R5: While the enable bit is 0, no branch is recorded.
- R6: With enable and freeze set and select bit 9 clear, an `irq_pending` cycle stops all captures from that cycle on. The stop stays in force after `irq_pending` falls and lasts until a control write with freeze = 0.
- R7: With select bit 9 set, `irq_pending` causes no freeze, and a branch arriving in the same cycle as `irq_pending` is recorded.
- R8: The stored source word carries mispredict in bit AW−1, in-transaction in bit AW−2 and abort in bit AW−3 (three-flag format). On readout these bits are returned on their own outputs, and `rd_from` is the remaining low bits sign-extended from bit AW−4.
- R9: `rd_pred` is always the inverse of `rd_mispred`.
- R10: During the walk, a record whose abort flag is set replaces the previously emitted record when at least one record precedes it, and the count drops by one. An abort record in the newest position is emitted normally.
- R11: After `rd_start`, records appear with `rd_valid` for one cycle each and `rd_last` on the final one. `done_valid` pulses with `done_count` on the following cycle.
- R12: Branches presented while a walk is in progress (`rd_busy`=1) are not recorded.
- R13: A `clr` pulse zeroes every stored source and target word and leaves tos where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_enable | input | 1 | Capture enable value to write |
| ctl_freeze | input | 1 | Freeze-on-interrupt value to write |
| ctl_select | input | 10 | Select word to write (bits 0-8 suppress, bit 9 call-stack mode) |
| irq_pending | input | 1 | Performance interrupt pending |
| clr | input | 1 | Zero all stored records |
| br_valid | input | 1 | A taken branch is presented |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| br_class | input | 3 | Branch class code |
| br_tgt_ring0 | input | 1 | Target is at the most privileged level |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch inside a transaction |
| br_abort | input | 1 | Branch is a transaction abort |
| rd_start | input | 1 | Start a readout walk |
| rd_busy | output | 1 | Walk in progress |
| rd_valid | output | 1 | Readout record strobe |
| rd_last | output | 1 | Final record of the walk |
| rd_from | output | AW | Sign-extended source address |
| rd_to | output | AW | Target address |
| rd_mispred | output | 1 | Mispredict flag of the record |
| rd_pred | output | 1 | Predicted flag of the record |
| rd_in_tx | output | 1 | In-transaction flag of the record |
| rd_abort | output | 1 | Abort flag of the record |
| done_valid | output | 1 | Walk count strobe |
| done_count | output | $clog2(DEPTH)+1 | Number of records emitted |

## Verification
The bench builds the block with a depth of 4, 32-bit addresses, the three-flag format and abort folding on. With the small depth, a handful of branches wraps the pointer and exposes both the overwrite of the oldest slot and the zero slots left by reset or clear. The 32-bit width puts the sign-extension boundary at bit 28, where a chosen source address shows the extension directly. A reference store in the bench predicts every walk, including folded abort chains, a newest abort and branches injected mid-walk.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

    localparam int SEL_W      = 10;
    localparam int SEL_RING0  = 0;
    localparam int SEL_RINGN  = 1;
    localparam int SEL_CLASS0 = 2;
    localparam int SEL_CSTACK = 9;

    typedef enum logic [2:0] {
        BR_COND     = 3'd0,
        BR_REL_CALL = 3'd1,
        BR_IND_CALL = 3'd2,
        BR_RET      = 3'd3,
        BR_IND_JMP  = 3'd4,
        BR_REL_JMP  = 3'd5,
        BR_FAR      = 3'd6,
        BR_OTHER    = 3'd7
    } br_class_e;

    typedef struct packed {
        logic             enable;
        logic             freeze;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_WALK,
        RD_FLUSH,
        RD_DONE
    } rd_state_e;

    // True when the select word blocks this branch (suppress-mode bits).
    function automatic logic capture_blocked(
        input logic [SEL_W-1:0] sel,
        input logic [2:0]       cls,
        input logic             ring0
    );
        logic       hit;
        logic [3:0] pos;
        hit = ring0 ? sel[SEL_RING0] : sel[SEL_RINGN];
        pos = 4'(cls) + 4'(SEL_CLASS0);
        if (cls == BR_OTHER)
            hit = 1'b1;
        else
            hit = hit | sel[pos];
        return hit;
    endfunction

endpackage

// File: rtl/lbr_capture_filter.sv
module lbr_capture_filter
    import lbr_pkg::*;
#(
    parameter int AW = 64,
    parameter int FC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_we,
    input  ctl_t          ctl_wdata,
    input  logic          irq_pending,
    input  logic          walk_busy,
    input  logic          br_valid,
    input  logic [AW-1:0] br_from,
    input  logic [2:0]    br_class,
    input  logic          br_ring0,
    input  logic          br_mispred,
    input  logic          br_in_tx,
    input  logic          br_abort,
    output logic          wr_en,
    output logic [AW-1:0] wr_word,
    output logic          frozen,
    output logic          enabled
);

    ctl_t ctl_q;
    logic frozen_q;
    logic freeze_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            frozen_q <= 1'b0;
        end else begin
            if (ctl_we)
                ctl_q <= ctl_wdata;
            if (ctl_we && !ctl_wdata.freeze)
                frozen_q <= 1'b0;
            else if (freeze_hit)
                frozen_q <= 1'b1;
        end
    end

    assign freeze_hit = ctl_q.enable & ctl_q.freeze & ~ctl_q.sel[SEL_CSTACK] & irq_pending;

    assign wr_en = br_valid & ctl_q.enable & ~frozen_q & ~freeze_hit & ~walk_busy
                 & ~capture_blocked(ctl_q.sel, br_class, br_ring0);

    assign frozen  = frozen_q;
    assign enabled = ctl_q.enable;

    generate
        if (FC == 3) begin : g_tx_flags
            logic unused_hi;
            assign unused_hi = ^br_from[AW-1:AW-3];
            assign wr_word   = {br_mispred, br_in_tx, br_abort, br_from[AW-4:0]};
        end else begin : g_mis_flag
            logic unused_hi;
            assign unused_hi = br_from[AW-1] ^ br_in_tx ^ br_abort;
            assign wr_word   = {br_mispred, br_from[AW-2:0]};
        end
    endgenerate

endmodule

// File: rtl/lbr_store.sv
module lbr_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_from,
    input  logic [AW-1:0] wr_to,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_from,
    output logic [AW-1:0] rd_to,
    output logic [IW-1:0] tos
);

    logic [AW-1:0] from_q [DEPTH];
    logic [AW-1:0] to_q   [DEPTH];
    logic [IW-1:0] tos_q;
    logic [IW-1:0] tos_nxt;

    assign tos_nxt = tos_q + IW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                from_q[s] <= '0;
                to_q[s]   <= '0;
            end
        end else if (clr) begin
            for (int s = 0; s < DEPTH; s++) begin
                from_q[s] <= '0;
                to_q[s]   <= '0;
            end
        end else if (wr_en) begin
            tos_q           <= tos_nxt;
            from_q[tos_nxt] <= wr_from;
            to_q[tos_nxt]   <= wr_to;
        end
    end

    assign rd_from = from_q[rd_idx];
    assign rd_to   = to_q[rd_idx];
    assign tos     = tos_q;

endmodule

// File: rtl/lbr_readout.sv
module lbr_readout
    import lbr_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int AW       = 64,
    parameter int FC       = 3,
    parameter bit COLLAPSE = 1'b1,
    localparam int IW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] tos,
    input  logic [AW-1:0] slot_from,
    input  logic [AW-1:0] slot_to,
    output logic [IW-1:0] rd_idx,
    output logic          busy,
    output logic          o_valid,
    output logic          o_last,
    output logic [AW-1:0] o_from,
    output logic [AW-1:0] o_to,
    output logic          o_mis,
    output logic          o_pred,
    output logic          o_intx,
    output logic          o_abort,
    output logic          done_valid,
    output logic [IW:0]   done_count
);

    rd_state_e state;
    logic [IW:0] step;
    logic [IW:0] count;

    // record held back one step so a following abort can replace it
    logic          p_have;
    logic [AW-1:0] p_from, p_to;
    logic          p_mis, p_intx, p_abort;

    logic signed [AW-1:0] shifted;
    logic [AW-1:0]        d_from;
    logic                 d_mis, d_intx, d_abort;
    logic                 fold;

    assign rd_idx  = tos - step[IW-1:0];
    assign shifted = $signed(slot_from << FC);
    assign d_from  = shifted >>> FC;
    assign d_mis   = slot_from[AW-1];

    generate
        if (FC == 3) begin : g_tx_dec
            assign d_intx  = slot_from[AW-2];
            assign d_abort = slot_from[AW-3];
        end else begin : g_mis_dec
            assign d_intx  = 1'b0;
            assign d_abort = 1'b0;
        end
    endgenerate

    assign fold = COLLAPSE && d_abort && p_have;
    assign busy = (state != RD_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RD_IDLE;
            step       <= '0;
            count      <= '0;
            p_have     <= 1'b0;
            p_from     <= '0;
            p_to       <= '0;
            p_mis      <= 1'b0;
            p_intx     <= 1'b0;
            p_abort    <= 1'b0;
            o_valid    <= 1'b0;
            o_last     <= 1'b0;
            o_from     <= '0;
            o_to       <= '0;
            o_mis      <= 1'b0;
            o_pred     <= 1'b0;
            o_intx     <= 1'b0;
            o_abort    <= 1'b0;
            done_valid <= 1'b0;
            done_count <= '0;
        end else begin
            o_valid    <= 1'b0;
            o_last     <= 1'b0;
            done_valid <= 1'b0;
            unique case (state)
                RD_IDLE: begin
                    if (start) begin
                        state  <= RD_WALK;
                        step   <= '0;
                        count  <= '0;
                        p_have <= 1'b0;
                    end
                end
                RD_WALK: begin
                    if (!fold && p_have) begin
                        o_valid <= 1'b1;
                        o_from  <= p_from;
                        o_to    <= p_to;
                        o_mis   <= p_mis;
                        o_pred  <= ~p_mis;
                        o_intx  <= p_intx;
                        o_abort <= p_abort;
                    end
                    p_have  <= 1'b1;
                    p_from  <= d_from;
                    p_to    <= slot_to;
                    p_mis   <= d_mis;
                    p_intx  <= d_intx;
                    p_abort <= d_abort;
                    if (!fold)
                        count <= count + 1'b1;
                    step <= step + 1'b1;
                    if (step == (IW+1)'(DEPTH - 1))
                        state <= RD_FLUSH;
                end
                RD_FLUSH: begin
                    o_valid <= 1'b1;
                    o_last  <= 1'b1;
                    o_from  <= p_from;
                    o_to    <= p_to;
                    o_mis   <= p_mis;
                    o_pred  <= ~p_mis;
                    o_intx  <= p_intx;
                    o_abort <= p_abort;
                    state   <= RD_DONE;
                end
                RD_DONE: begin
                    done_valid <= 1'b1;
                    done_count <= count;
                    state      <= RD_IDLE;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lbr_ring.sv
module lbr_ring
    import lbr_pkg::*;
#(
    parameter int DEPTH          = 16,
    parameter int AW             = 64,
    parameter bit TX_FLAGS       = 1'b1,
    parameter bit COLLAPSE_ABORT = 1'b1,
    localparam int IW            = $clog2(DEPTH),
    localparam int FC            = TX_FLAGS ? 3 : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic             ctl_enable,
    input  logic             ctl_freeze,
    input  logic [SEL_W-1:0] ctl_select,
    input  logic             irq_pending,
    input  logic             clr,
    input  logic             br_valid,
    input  logic [AW-1:0]    br_from,
    input  logic [AW-1:0]    br_to,
    input  logic [2:0]       br_class,
    input  logic             br_tgt_ring0,
    input  logic             br_mispred,
    input  logic             br_in_tx,
    input  logic             br_abort,
    input  logic             rd_start,
    output logic             rd_busy,
    output logic             rd_valid,
    output logic             rd_last,
    output logic [AW-1:0]    rd_from,
    output logic [AW-1:0]    rd_to,
    output logic             rd_mispred,
    output logic             rd_pred,
    output logic             rd_in_tx,
    output logic             rd_abort,
    output logic             done_valid,
    output logic [IW:0]      done_count
);

    ctl_t          ctl_wdata;
    logic          wr_en;
    logic [AW-1:0] wr_word;
    logic          frozen;
    logic          ctl_en;
    logic [IW-1:0] tos;
    logic [IW-1:0] rd_idx;
    logic [AW-1:0] slot_from, slot_to;

    assign ctl_wdata = '{enable: ctl_enable, freeze: ctl_freeze, sel: ctl_select};

    lbr_capture_filter #(.AW(AW), .FC(FC)) u_filter (
        .clk         (clk),
        .rst         (rst),
        .ctl_we      (ctl_we),
        .ctl_wdata   (ctl_wdata),
        .irq_pending (irq_pending),
        .walk_busy   (rd_busy),
        .br_valid    (br_valid),
        .br_from     (br_from),
        .br_class    (br_class),
        .br_ring0    (br_tgt_ring0),
        .br_mispred  (br_mispred),
        .br_in_tx    (br_in_tx),
        .br_abort    (br_abort),
        .wr_en       (wr_en),
        .wr_word     (wr_word),
        .frozen      (frozen),
        .enabled     (ctl_en)
    );

    lbr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_from (wr_word),
        .wr_to   (br_to),
        .rd_idx  (rd_idx),
        .rd_from (slot_from),
        .rd_to   (slot_to),
        .tos     (tos)
    );

    lbr_readout #(.DEPTH(DEPTH), .AW(AW), .FC(FC), .COLLAPSE(COLLAPSE_ABORT)) u_readout (
        .clk        (clk),
        .rst        (rst),
        .start      (rd_start),
        .tos        (tos),
        .slot_from  (slot_from),
        .slot_to    (slot_to),
        .rd_idx     (rd_idx),
        .busy       (rd_busy),
        .o_valid    (rd_valid),
        .o_last     (rd_last),
        .o_from     (rd_from),
        .o_to       (rd_to),
        .o_mis      (rd_mispred),
        .o_pred     (rd_pred),
        .o_intx     (rd_in_tx),
        .o_abort    (rd_abort),
        .done_valid (done_valid),
        .done_count (done_count)
    );

endmodule

// File: rtl/lbr_ring_chk.sv
module lbr_ring_chk #(
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic [IW-1:0] tos,
    input logic          frozen,
    input logic          ctl_en,
    input logic          rd_busy,
    input logic          rd_valid,
    input logic          rd_last,
    input logic          rd_mispred,
    input logic          rd_pred,
    input logic          done_valid,
    input logic [IW:0]   done_count
);

    // R6: a held freeze keeps the pointer still
    a_r6_frozen_tos_still: assert property (@(posedge clk) disable iff (rst)
        frozen |=> $stable(tos));

    // R5: capture disabled means no pointer movement
    a_r5_disabled_no_write: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> $stable(tos));

    // R12: nothing is written while a walk runs
    a_r12_walk_blocks_write: assert property (@(posedge clk) disable iff (rst)
        rd_busy |=> $stable(tos));

    // R11: the last flag only accompanies a record
    a_r11_last_has_valid: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    // R11: count strobe follows the final record
    a_r11_done_after_last: assert property (@(posedge clk) disable iff (rst)
        rd_last |=> done_valid);

    // R10: folding never removes every record nor adds any
    a_r10_count_range: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_count >= 1 && done_count <= (IW+1)'(DEPTH)));

    // R9: predicted and mispredicted are exclusive on every record
    a_r9_pred_inverse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $countones({rd_pred, rd_mispred}) == 1);

endmodule

bind lbr_ring lbr_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tos        (tos),
    .frozen     (frozen),
    .ctl_en     (ctl_en),
    .rd_busy    (rd_busy),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .rd_mispred (rd_mispred),
    .rd_pred    (rd_pred),
    .done_valid (done_valid),
    .done_count (done_count)
);

// File: tb/lbr_ring_tb.sv
module lbr_ring_tb;

    localparam int CLK_P = 10;
    localparam int DEPTH = 4;
    localparam int AW    = 32;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ctl_we = 1'b0, ctl_enable = 1'b0, ctl_freeze = 1'b0;
    logic [9:0]    ctl_select = '0;
    logic          irq_pending = 1'b0, clr = 1'b0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_from = '0, br_to = '0;
    logic [2:0]    br_class = '0;
    logic          br_tgt_ring0 = 1'b0, br_mispred = 1'b0, br_in_tx = 1'b0, br_abort = 1'b0;
    logic          rd_start = 1'b0;
    logic          rd_busy, rd_valid, rd_last, rd_mispred, rd_pred, rd_in_tx, rd_abort;
    logic [AW-1:0] rd_from, rd_to;
    logic          done_valid;
    logic [IW:0]   done_count;

    always #(CLK_P/2) clk = ~clk;

    lbr_ring #(.DEPTH(DEPTH), .AW(AW), .TX_FLAGS(1'b1), .COLLAPSE_ABORT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_enable(ctl_enable), .ctl_freeze(ctl_freeze),
        .ctl_select(ctl_select), .irq_pending(irq_pending), .clr(clr), .br_valid(br_valid),
        .br_from(br_from), .br_to(br_to), .br_class(br_class), .br_tgt_ring0(br_tgt_ring0),
        .br_mispred(br_mispred), .br_in_tx(br_in_tx), .br_abort(br_abort), .rd_start(rd_start),
        .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_last(rd_last), .rd_from(rd_from), .rd_to(rd_to),
        .rd_mispred(rd_mispred), .rd_pred(rd_pred), .rd_in_tx(rd_in_tx), .rd_abort(rd_abort),
        .done_valid(done_valid), .done_count(done_count)
    );

    typedef struct {
        logic [AW-1:0] f;
        logic [AW-1:0] t;
        logic m, i, a, l;
    } exp_t;

    exp_t  sb[$];
    exp_t  cur;
    int    exp_count;
    int    checks = 0;
    int    errors = 0;
    bit    done_seen;
    string cur_tag = "";

    // reference store, filled only with branches the requirements say are kept
    logic [AW-1:0] mf[DEPTH];
    logic [AW-1:0] mt[DEPTH];
    logic          mm[DEPTH], mi[DEPTH], ma[DEPTH];
    int            mtos = 0;

    function automatic void model_clear();
        for (int s = 0; s < DEPTH; s++) begin
            mf[s] = '0; mt[s] = '0; mm[s] = 0; mi[s] = 0; ma[s] = 0;
        end
    endfunction

    function automatic void build_expect();
        exp_t lst[$];
        exp_t e;
        for (int k = 0; k < DEPTH; k++) begin
            int s;
            s   = (mtos - k + DEPTH) % DEPTH;
            e.f = {{3{mf[s][AW-4]}}, mf[s][AW-4:0]};
            e.t = mt[s];
            e.m = mm[s]; e.i = mi[s]; e.a = ma[s]; e.l = 1'b0;
            if (e.a && lst.size() > 0) lst[lst.size()-1] = e;
            else lst.push_back(e);
        end
        lst[lst.size()-1].l = 1'b1;
        exp_count = lst.size();
        foreach (lst[k]) sb.push_back(lst[k]);
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected record from=%h expected none", cur_tag, rd_from);
                end else begin
                    cur = sb.pop_front();
                    if (rd_from !== cur.f || rd_to !== cur.t || rd_mispred !== cur.m ||
                        rd_pred !== !cur.m || rd_in_tx !== cur.i || rd_abort !== cur.a ||
                        rd_last !== cur.l) begin
                        errors++;
                        $display("FAIL %s: got from=%h to=%h m=%b p=%b i=%b a=%b l=%b expected from=%h to=%h m=%b p=%b i=%b a=%b l=%b",
                                 cur_tag, rd_from, rd_to, rd_mispred, rd_pred, rd_in_tx, rd_abort, rd_last,
                                 cur.f, cur.t, cur.m, !cur.m, cur.i, cur.a, cur.l);
                    end
                end
            end
            if (done_valid) begin
                checks++;
                done_seen = 1'b1;
                if (int'(done_count) != exp_count) begin
                    errors++;
                    $display("FAIL %s R11: count got %0d expected %0d", cur_tag, done_count, exp_count);
                end
            end
        end
    end

    task automatic ctl(input logic en, input logic frz, input logic [9:0] sel);
        @(negedge clk);
        ctl_we = 1'b1; ctl_enable = en; ctl_freeze = frz; ctl_select = sel;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic branch(input logic [AW-1:0] f, input logic [AW-1:0] t, input logic [2:0] c,
                          input logic r0, input logic m, input logic i, input logic a,
                          input logic irq, input bit keep);
        @(negedge clk);
        br_valid = 1'b1; br_from = f; br_to = t; br_class = c; br_tgt_ring0 = r0;
        br_mispred = m; br_in_tx = i; br_abort = a; irq_pending = irq;
        @(negedge clk);
        br_valid = 1'b0; irq_pending = 1'b0;
        if (keep) begin
            mtos = (mtos + 1) % DEPTH;
            mf[mtos] = f; mt[mtos] = t; mm[mtos] = m; mi[mtos] = i; ma[mtos] = a;
        end
    endtask

    task automatic irq_pulse();
        @(negedge clk);
        irq_pending = 1'b1;
        @(negedge clk);
        irq_pending = 1'b0;
    endtask

    task automatic readout(input string tag, input bit inject);
        build_expect();
        cur_tag   = tag;
        done_seen = 1'b0;
        @(negedge clk);
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        if (inject) begin
            br_valid = 1'b1; br_from = 32'h0000_7777; br_to = 32'h0000_8888;
            br_class = 3'd0; br_tgt_ring0 = 1'b0; br_abort = 1'b0;
            @(negedge clk);
            br_valid = 1'b0;
        end
        for (int k = 0; k < 40 && !done_seen; k++) @(negedge clk);
        checks++;
        if (!done_seen || sb.size() != 0) begin
            errors++;
            $display("FAIL %s R11: walk done=%0b leftover=%0d expected done=1 leftover=0",
                     tag, done_seen, sb.size());
            sb.delete();
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        readout("R1 reset state", 1'b0);

        ctl(1'b1, 1'b0, 10'h000);
        branch(32'h0000_0100, 32'h0000_0200, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        branch(32'h0000_0110, 32'h0000_0210, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        branch(32'h0000_0120, 32'h0000_0220, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R2 partial fill", 1'b0);

        branch(32'h0000_0130, 32'h0000_0230, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        branch(32'h1000_0140, 32'h0000_0240, 3'd6, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        branch(32'hE000_0150, 32'h0000_0250, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        readout("R2 R8 R9 wrap and sign extension", 1'b0);

        ctl(1'b1, 1'b0, 10'b00_0000_0001);
        branch(32'h0000_0300, 32'h0000_0400, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        branch(32'h0000_0310, 32'h0000_0410, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ctl(1'b1, 1'b0, 10'b00_0000_0010);
        branch(32'h0000_0320, 32'h0000_0420, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        branch(32'h0000_0330, 32'h0000_0430, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R3 privilege suppress", 1'b0);

        ctl(1'b1, 1'b0, 10'b00_0010_0000);
        branch(32'h0000_0500, 32'h0000_0600, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        branch(32'h0000_0510, 32'h0000_0610, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        ctl(1'b1, 1'b0, 10'h000);
        branch(32'h0000_0520, 32'h0000_0620, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        branch(32'h0000_0530, 32'h0000_0630, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R4 class suppress", 1'b0);

        ctl(1'b0, 1'b0, 10'h000);
        branch(32'h0000_0700, 32'h0000_0800, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        readout("R5 disabled", 1'b0);

        ctl(1'b1, 1'b1, 10'h000);
        irq_pulse();
        branch(32'h0000_0900, 32'h0000_0A00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        branch(32'h0000_0910, 32'h0000_0A10, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        readout("R6 frozen", 1'b0);
        ctl(1'b1, 1'b0, 10'h000);
        branch(32'h0000_0920, 32'h0000_0A20, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R6 unfrozen", 1'b0);

        ctl(1'b1, 1'b1, 10'b10_0000_0000);
        branch(32'h0000_0B00, 32'h0000_0C00, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        branch(32'h0000_0B10, 32'h0000_0C10, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R7 call-stack ignores freeze", 1'b0);

        ctl(1'b1, 1'b0, 10'h000);
        branch(32'h0000_0D00, 32'h0000_0E00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        branch(32'h0000_0D10, 32'h0000_0E10, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        branch(32'h0000_0D20, 32'h0000_0E20, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R10 abort fold", 1'b0);
        branch(32'h0000_0D30, 32'h0000_0E30, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        readout("R10 newest abort", 1'b0);

        readout("R12 branch during walk", 1'b1);
        readout("R12 after walk", 1'b0);

        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        readout("R13 clear", 1'b0);
        branch(32'h0000_0F00, 32'h0000_0F80, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        readout("R13 write after clear", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule